// File: doc/BRIEF.md
# Fused multiply-add significand datapath (align, add, normalize)

This block forms the unrounded result of `x*y ± z` for finite, nonzero, normal single-precision operands. It receives each operand already unpacked: a sign, an unbiased signed exponent, and a 24-bit significand with the hidden one included. The multiply is exact. The product is never rounded before the addend joins it, so the only information lost comes from a sticky bit that a later rounding stage uses.

The product and the addend are each placed in a 64-bit working word with the leading one at bit 62. The operand with the smaller exponent is shifted right with sticky collection. The two words are added or subtracted by their effective signs, and the sum is normalized back to bit 62. The word is then narrowed to 27 bits: 24 significand bits, then guard and round bits, then a sticky bit. A flag marks an addend of zero, and in that case the normalized product passes straight to the narrowing step. Rounding, packing and special operands belong to neighbouring stages.

The result is registered. `out_valid` pulses once for each accepted `in_valid`, after one cycle by default or after two cycles when the input register option is set.

Top module: `fused_madd_datapath`

## Requirements
- R1: The product is the exact 48-bit product of `x_sig` and `y_sig`, and its exponent is `x_exp + y_exp`. When the product is 2.0 or more, it is renormalized and the exponent is raised by one.
- R2: The product sign is `x_sign ^ y_sign`, inverted when `neg_prod` is 1.
- R3: When `z_is_zero` is 1, the `z_*` inputs are ignored. The result is then the narrowed product, with the product sign, and `res_zero` is 0.
- R4: The operand with the smaller exponent is aligned by a right shift in which every discarded bit is ORed into bit 0. This includes shifts of 64 places or more. The narrowed result equals the exact sum, truncated, with a correct sticky bit.
- R5: When the effective signs are equal, the magnitudes add. A carry into the next binade shifts the sum right by one, keeping sticky, and raises the exponent by one.
- R6: When the effective signs differ, the smaller magnitude is subtracted from the larger, and the result takes the sign of the larger.
- R7: An exact cancellation gives `res_zero`=1, `res_sig`=0 and `res_exp`=0. `res_sign` equals `rm_down`, where 1 means round toward negative.
- R8: Every nonzero result is normalized, so `res_sig[26]` is 1. The magnitude equals `res_sig * 2^(res_exp-26)`, taken before the sticky bit is applied.
- R9: `res_sig[26:1]` holds the 26 most significant bits of the exact magnitude. `res_sig[0]` is the next bit ORed with every bit below it.
- R10: `out_valid` is `in_valid` delayed by one cycle (two when `IN_REG`=1). The result outputs hold their values in every cycle in which `out_valid` is 0.
- R11: While reset is held, `out_valid`, `res_sign`, `res_exp`, `res_sig` and `res_zero` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are present this cycle |
| neg_prod | input | 1 | Negate the product (multiply-subtract) |
| z_is_zero | input | 1 | The addend is zero; skip the addition |
| rm_down | input | 1 | Rounding mode is toward negative (sign of an exact zero) |
| x_sign | input | 1 | Sign of x |
| x_exp | input | EXP_W | Unbiased signed exponent of x |
| x_sig | input | MANT_W | Significand of x, hidden one at the MSB |
| y_sign | input | 1 | Sign of y |
| y_exp | input | EXP_W | Unbiased signed exponent of y |
| y_sig | input | MANT_W | Significand of y |
| z_sign | input | 1 | Sign of z |
| z_exp | input | EXP_W | Unbiased signed exponent of z |
| z_sig | input | MANT_W | Significand of z |
| out_valid | output | 1 | Result is valid |
| res_sign | output | 1 | Result sign |
| res_exp | output | EXP_W+2 | Signed exponent of the result's leading bit |
| res_sig | output | OUT_W | Narrowed significand: 24 bits, guard, round, sticky |
| res_zero | output | 1 | Exact zero result |

## Verification
Some properties can be checked on every cycle whatever the operand values, and the assertions cover these:
- the leading one sits at the top of every nonzero result;
- a zero result has the zero encoding and takes its sign from the rounding-mode input;
- the latency of the valid signal is fixed and results hold while idle;
- the addend-zero bypass never produces zero.

The arithmetic itself can only be shown by scenarios:
- the exact value and sticky bit after far alignment;
- the carry on equal-sign addition;
- deep normalization after near-total cancellation;
- the sign of a negated product.

The bench checks these against an exact wide-integer sum, using directed corner cases and random operands.

// File: rtl/fma_dp_pkg.sv
package fma_dp_pkg;
   localparam int FMA_MANT_W = 24;
   localparam int FMA_EXP_W  = 10;
   localparam int FMA_WORK_W = 64;
   localparam int FMA_OUT_W  = 27;

   typedef enum logic [1:0] {
      EFF_BYPASS = 2'd0,
      EFF_ADD    = 2'd1,
      EFF_SUB    = 2'd2
   } eff_op_e;
endpackage

// File: rtl/fma_sticky_shr.sv
module fma_sticky_shr #(
   parameter int W    = 64,
   parameter int SH_W = 7
) (
   input  logic [W-1:0]    din,
   input  logic [SH_W-1:0] amt,
   output logic [W-1:0]    dout
);
   logic [W-1:0] lost_mask;

   always_comb begin
      lost_mask = '0;
      if (int'(amt) >= W) begin
         dout    = '0;
         dout[0] = |din;
      end else begin
         lost_mask = ~({W{1'b1}} << amt);
         dout      = din >> amt;
         dout[0]   = dout[0] | (|(din & lost_mask));
      end
   end
endmodule

// File: rtl/fma_prod_place.sv
module fma_prod_place #(
   parameter int MANT_W    = 24,
   parameter int EXP_W     = 10,
   parameter int WORK_W    = 64,
   parameter int RES_EXP_W = 12
) (
   input  logic                        xs,
   input  logic signed [EXP_W-1:0]     xe,
   input  logic [MANT_W-1:0]           xm,
   input  logic                        ys,
   input  logic signed [EXP_W-1:0]     ye,
   input  logic [MANT_W-1:0]           ym,
   input  logic                        neg,
   output logic                        p_sign,
   output logic signed [RES_EXP_W-1:0] p_exp,
   output logic [WORK_W-1:0]           p_word
);
   localparam int PW = 2 * MANT_W;
   localparam int UP = WORK_W - PW;

   logic [PW-1:0]               prod;
   logic [WORK_W-1:0]           raw;
   logic signed [RES_EXP_W-1:0] esum;

   assign prod   = PW'(xm) * PW'(ym);
   assign raw    = {prod, {UP{1'b0}}};
   assign esum   = RES_EXP_W'(xe) + RES_EXP_W'(ye);
   assign p_sign = xs ^ ys ^ neg;

   always_comb begin
      if (raw[WORK_W-1]) begin
         p_word = raw >> 1;
         p_exp  = esum + RES_EXP_W'(1);
      end else begin
         p_word = raw;
         p_exp  = esum;
      end
   end
endmodule

// File: rtl/fma_add_norm.sv
module fma_add_norm
   import fma_dp_pkg::*;
#(
   parameter int WORK_W    = 64,
   parameter int RES_EXP_W = 12,
   parameter int SH_W      = 7
) (
   input  logic                        p_sign,
   input  logic signed [RES_EXP_W-1:0] p_exp,
   input  logic [WORK_W-1:0]           p_word,
   input  logic                        z_sign,
   input  logic signed [RES_EXP_W-1:0] z_exp,
   input  logic [WORK_W-1:0]           z_word,
   input  logic                        z_is_zero,
   input  logic                        rm_down,
   output logic                        s_sign,
   output logic signed [RES_EXP_W-1:0] s_exp,
   output logic [WORK_W-1:0]           s_word,
   output logic                        s_zero
);
   localparam int LEAD = WORK_W - 2;
   localparam int DW   = RES_EXP_W + 1;

   logic signed [DW-1:0]        ediff;
   logic [DW-1:0]               emag;
   logic                        z_ahead;
   logic [SH_W-1:0]             amt, lead_pos, norm_sh;
   logic [WORK_W-1:0]           small_raw, small_al, pa, za, add_w, sub_w, norm_w;
   logic signed [RES_EXP_W-1:0] big_exp;
   logic                        p_larger;
   eff_op_e                     op;

   // exponent compare picks the operand that must move right
   assign ediff     = DW'(z_exp) - DW'(p_exp);
   assign z_ahead   = (ediff > 0);
   assign emag      = z_ahead ? DW'(ediff) : DW'(-ediff);
   assign amt       = (emag >= DW'(WORK_W)) ? SH_W'(WORK_W) : SH_W'(emag);
   assign small_raw = z_ahead ? p_word : z_word;
   assign big_exp   = z_ahead ? z_exp : p_exp;

   fma_sticky_shr #(.W(WORK_W), .SH_W(SH_W)) u_align (
      .din  (small_raw),
      .amt  (amt),
      .dout (small_al)
   );

   assign pa       = z_ahead ? small_al : p_word;
   assign za       = z_ahead ? z_word : small_al;
   assign p_larger = (pa >= za);
   assign add_w    = pa + za;
   assign sub_w    = p_larger ? (pa - za) : (za - pa);

   always_comb begin
      lead_pos = '0;
      for (int i = 0; i <= LEAD; i++) begin
         if (sub_w[i]) lead_pos = SH_W'(i);
      end
   end

   assign norm_sh = SH_W'(LEAD) - lead_pos;
   assign norm_w  = sub_w << norm_sh;

   assign op = z_is_zero ? EFF_BYPASS : ((p_sign == z_sign) ? EFF_ADD : EFF_SUB);

   always_comb begin
      s_sign = p_sign;
      s_exp  = p_exp;
      s_word = p_word;
      s_zero = 1'b0;
      case (op)
         EFF_ADD: begin
            if (add_w[WORK_W-1]) begin
               s_word = {1'b0, add_w[WORK_W-1:1]} | {{(WORK_W-1){1'b0}}, add_w[0]};
               s_exp  = big_exp + RES_EXP_W'(1);
            end else begin
               s_word = add_w;
               s_exp  = big_exp;
            end
         end
         EFF_SUB: begin
            if (sub_w == '0) begin
               s_zero = 1'b1;
               s_sign = rm_down;
               s_exp  = '0;
               s_word = '0;
            end else begin
               s_sign = p_larger ? p_sign : z_sign;
               s_word = norm_w;
               s_exp  = big_exp - RES_EXP_W'(norm_sh);
            end
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/fused_madd_datapath.sv
module fused_madd_datapath
   import fma_dp_pkg::*;
#(
   parameter int MANT_W = FMA_MANT_W,
   parameter int EXP_W  = FMA_EXP_W,
   parameter int WORK_W = FMA_WORK_W,
   parameter int OUT_W  = FMA_OUT_W,
   parameter int IN_REG = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic                    neg_prod,
   input  logic                    z_is_zero,
   input  logic                    rm_down,
   input  logic                    x_sign,
   input  logic signed [EXP_W-1:0] x_exp,
   input  logic [MANT_W-1:0]       x_sig,
   input  logic                    y_sign,
   input  logic signed [EXP_W-1:0] y_exp,
   input  logic [MANT_W-1:0]       y_sig,
   input  logic                    z_sign,
   input  logic signed [EXP_W-1:0] z_exp,
   input  logic [MANT_W-1:0]       z_sig,
   output logic                    out_valid,
   output logic                    res_sign,
   output logic signed [EXP_W+1:0] res_exp,
   output logic [OUT_W-1:0]        res_sig,
   output logic                    res_zero
);
   localparam int RES_EXP_W = EXP_W + 2;
   localparam int SH_W      = $clog2(WORK_W) + 1;
   localparam int LEAD      = WORK_W - 2;
   localparam int Z_UP      = LEAD - (MANT_W - 1);
   localparam int CMP_SH    = LEAD - (OUT_W - 1);
   localparam int OPW       = 1 + EXP_W + MANT_W;
   localparam int BW        = 4 + 3 * OPW;

   if (WORK_W < 2 * MANT_W + 1) begin : g_bad_work
      $error("WORK_W too narrow for the exact product");
   end
   if (OUT_W < MANT_W + 3 || CMP_SH < 1) begin : g_bad_out
      $error("OUT_W must hold significand, guard, round, sticky and fit the work word");
   end

   logic [BW-1:0] in_bus, st_bus;
   logic st_valid, st_neg, st_zz, st_rmd, st_xs, st_ys, st_zs;
   logic signed [EXP_W-1:0] st_xe, st_ye, st_ze;
   logic [MANT_W-1:0] st_xm, st_ym, st_zm;

   assign in_bus = {in_valid, neg_prod, z_is_zero, rm_down,
                    x_sign, x_exp, x_sig, y_sign, y_exp, y_sig, z_sign, z_exp, z_sig};

   if (IN_REG != 0) begin : g_in_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st_bus <= '0;
         else        st_bus <= in_bus;
      end
   end else begin : g_in_wire
      assign st_bus = in_bus;
   end

   assign {st_valid, st_neg, st_zz, st_rmd,
           st_xs, st_xe, st_xm, st_ys, st_ye, st_ym, st_zs, st_ze, st_zm} = st_bus;

   logic                        p_sign, s_sign, s_zero;
   logic signed [RES_EXP_W-1:0] p_exp, s_exp, z_exp_w;
   logic [WORK_W-1:0]           p_word, z_word, s_word;
   logic [OUT_W-1:0]            sig_d;
   logic                        unused_top;

   fma_prod_place #(.MANT_W(MANT_W), .EXP_W(EXP_W), .WORK_W(WORK_W), .RES_EXP_W(RES_EXP_W)) u_prod (
      .xs(st_xs), .xe(st_xe), .xm(st_xm),
      .ys(st_ys), .ye(st_ye), .ym(st_ym),
      .neg(st_neg),
      .p_sign(p_sign), .p_exp(p_exp), .p_word(p_word)
   );

   assign z_word  = {{(WORK_W-MANT_W){1'b0}}, st_zm} << Z_UP;
   assign z_exp_w = RES_EXP_W'(st_ze);

   fma_add_norm #(.WORK_W(WORK_W), .RES_EXP_W(RES_EXP_W), .SH_W(SH_W)) u_sum (
      .p_sign(p_sign), .p_exp(p_exp), .p_word(p_word),
      .z_sign(st_zs), .z_exp(z_exp_w), .z_word(z_word),
      .z_is_zero(st_zz), .rm_down(st_rmd),
      .s_sign(s_sign), .s_exp(s_exp), .s_word(s_word), .s_zero(s_zero)
   );

   // narrow: keep the top OUT_W-1 bits below the carry slot, fold the rest into sticky
   assign sig_d      = {s_word[LEAD -: OUT_W-1], |s_word[CMP_SH:0]};
   assign unused_top = s_word[WORK_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         res_sign  <= 1'b0;
         res_exp   <= '0;
         res_sig   <= '0;
         res_zero  <= 1'b0;
      end else begin
         out_valid <= st_valid;
         if (st_valid) begin
            res_sign <= s_sign;
            res_exp  <= s_exp;
            res_sig  <= sig_d;
            res_zero <= s_zero;
         end
      end
   end
endmodule

// File: rtl/fma_dp_checker.sv
module fma_dp_checker #(
   parameter int RES_EXP_W = 12,
   parameter int OUT_W     = 27,
   parameter int IN_REG    = 0
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        in_valid,
   input logic                        z_is_zero,
   input logic                        rm_down,
   input logic                        out_valid,
   input logic                        res_sign,
   input logic signed [RES_EXP_W-1:0] res_exp,
   input logic [OUT_W-1:0]            res_sig,
   input logic                        res_zero
);
   p_lead_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !res_zero) |-> res_sig[OUT_W-1]);

   p_zero_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && res_zero) |-> (res_sig == '0 && res_exp == '0));

   p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(res_sig) && $stable(res_exp) && $stable(res_sign) && $stable(res_zero)));

   if (IN_REG == 0) begin : g_lat1
      p_valid_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> $past(in_valid));
      p_zero_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && res_zero) |-> (res_sign == $past(rm_down)));
      p_bypass_nz_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && z_is_zero) |=> !res_zero);
   end else begin : g_lat2
      p_valid_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |-> ##2 out_valid);
      p_zero_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && res_zero) |-> (res_sign == $past(rm_down, 2)));
      p_bypass_nz_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && z_is_zero) |-> ##2 !res_zero);
   end
endmodule

bind fused_madd_datapath fma_dp_checker #(
   .RES_EXP_W(EXP_W + 2), .OUT_W(OUT_W), .IN_REG(IN_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .z_is_zero(z_is_zero),
   .rm_down(rm_down), .out_valid(out_valid), .res_sign(res_sign),
   .res_exp(res_exp), .res_sig(res_sig), .res_zero(res_zero)
);

// File: tb/fused_madd_datapath_tb.sv
module fused_madd_datapath_tb;
   localparam int MW = 24;
   localparam int EW = 10;
   localparam int OW = 27;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, neg_prod = 1'b0, z_is_zero = 1'b0, rm_down = 1'b0;
   logic x_sign = 1'b0, y_sign = 1'b0, z_sign = 1'b0;
   logic signed [EW-1:0] x_exp = '0, y_exp = '0, z_exp = '0;
   logic [MW-1:0] x_sig = '0, y_sig = '0, z_sig = '0;
   logic out_valid, res_sign, res_zero;
   logic signed [EW+1:0] res_exp;
   logic [OW-1:0] res_sig;

   always #2 clk = ~clk;

   fused_madd_datapath u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .neg_prod(neg_prod),
      .z_is_zero(z_is_zero), .rm_down(rm_down),
      .x_sign(x_sign), .x_exp(x_exp), .x_sig(x_sig),
      .y_sign(y_sign), .y_exp(y_exp), .y_sig(y_sig),
      .z_sign(z_sign), .z_exp(z_exp), .z_sig(z_sig),
      .out_valid(out_valid), .res_sign(res_sign), .res_exp(res_exp),
      .res_sig(res_sig), .res_zero(res_zero)
   );

   typedef struct {
      logic        sign;
      int          ex;
      logic [26:0] sig;
      logic        zero;
      string       tag;
   } exp_t;

   exp_t sb_q[$];
   exp_t last_e;
   int   n_checks = 0;
   int   n_fails  = 0;
   bit   finished = 0;

   // exact wide-integer model of x*y +/- z, narrowed to 27 bits with sticky
   function automatic exp_t ref_model(input logic xs, input int xe, input logic [23:0] xm,
                                      input logic ys, input int ye, input logic [23:0] ym,
                                      input logic zs, input int ze, input logic [23:0] zm,
                                      input logic neg, input logic zz, input logic rmd);
      exp_t r;
      logic [255:0] pw, zw, m;
      logic [47:0] pr;
      int pe0, zb, base, k;
      logic ps;
      pr   = 48'(xm) * 48'(ym);
      pe0  = xe + ye - 46;
      zb   = ze - 23;
      base = (zz || pe0 < zb) ? pe0 : zb;
      pw   = 256'(pr) << (pe0 - base);
      zw   = zz ? '0 : (256'(zm) << (zb - base));
      ps   = xs ^ ys ^ neg;
      r.tag = "";
      if (zz || ps == zs) begin
         m = pw + zw; r.sign = ps;
      end else if (pw >= zw) begin
         m = pw - zw; r.sign = ps;
      end else begin
         m = zw - pw; r.sign = zs;
      end
      if (m == '0) begin
         r.zero = 1'b1; r.sign = rmd; r.ex = 0; r.sig = '0;
         return r;
      end
      k = 0;
      for (int i = 0; i < 256; i++) if (m[i]) k = i;
      r.zero = 1'b0;
      r.ex   = base + k;
      if (k >= 26) begin
         r.sig = 27'(m >> (k - 26));
         if ((m & ((256'd1 << (k - 26)) - 256'd1)) != '0) r.sig[0] = 1'b1;
      end else begin
         r.sig = 27'(m << (26 - k));
      end
      return r;
   endfunction

   task automatic drive(input logic xs, input int xe, input logic [23:0] xm,
                        input logic ys, input int ye, input logic [23:0] ym,
                        input logic zs, input int ze, input logic [23:0] zm,
                        input logic neg, input logic zz, input logic rmd, input string tag);
      exp_t e;
      e = ref_model(xs, xe, xm, ys, ye, ym, zs, ze, zm, neg, zz, rmd);
      e.tag = tag;
      sb_q.push_back(e);
      x_sign = xs; x_exp = EW'(xe); x_sig = xm;
      y_sign = ys; y_exp = EW'(ye); y_sig = ym;
      z_sign = zs; z_exp = EW'(ze); z_sig = zm;
      neg_prod = neg; z_is_zero = zz; rm_down = rmd;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // monitor: pop expected items as results emerge
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && out_valid) begin
            n_checks++;
            if (sb_q.size() == 0) begin
               n_fails++;
               $display("FAIL R10: unexpected result got valid=1 expected no result");
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               last_e = e;
               if (res_sign !== e.sign || int'(res_exp) != e.ex || res_sig !== e.sig || res_zero !== e.zero) begin
                  n_fails++;
                  $display("FAIL %s: got sign=%0d exp=%0d sig=%h zero=%0d expected sign=%0d exp=%0d sig=%h zero=%0d",
                           e.tag, res_sign, int'(res_exp), res_sig, res_zero, e.sign, e.ex, e.sig, e.zero);
               end
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      n_checks++;
      if (out_valid !== 1'b0 || res_sig !== '0 || res_zero !== 1'b0 || res_exp !== '0 || res_sign !== 1'b0) begin
         n_fails++;
         $display("FAIL R11: got valid=%0d sig=%h zero=%0d expected all zero", out_valid, res_sig, res_zero);
      end
      rst_n = 1'b1;
      @(negedge clk);

      drive(0, 3, 24'hFFFFFF, 0, -2, 24'hFFFFFF, 0, -60, 24'h800000, 0, 0, 0, "R1");
      drive(0, 0, 24'hC00000, 0, 0, 24'h800000, 0, 2, 24'h800000, 1, 0, 0, "R2");
      drive(1, 3, 24'hC00000, 0, 0, 24'h800000, 0, 0, 24'h800000, 0, 0, 0, "R6");
      drive(0, 0, 24'h800000, 0, 0, 24'h800000, 1, 0, 24'h800000, 0, 0, 0, "R7");
      drive(0, 0, 24'h800000, 0, 0, 24'h800000, 1, 0, 24'h800000, 0, 0, 1, "R7");
      drive(1, 0, 24'h800000, 1, 0, 24'h800000, 0, 0, 24'h800000, 1, 0, 1, "R7");
      drive(0, 0, 24'h800001, 0, 0, 24'h800000, 1, 0, 24'h800000, 0, 0, 0, "R8");
      drive(0, 0, 24'hFFFFFF, 0, 0, 24'hFFFFFF, 1, 1, 24'hFFFFFE, 0, 0, 0, "R8");
      drive(0, 0, 24'hC00000, 0, 0, 24'hC00000, 0, 1, 24'hC00000, 0, 0, 0, "R5");
      drive(1, 0, 24'hFFFFFF, 0, 0, 24'hFFFFFF, 1, 1, 24'hFFFFFF, 0, 0, 0, "R5");
      drive(0, 2, 24'hA5A5A5, 1, 1, 24'h812345, 1, 5, 24'hFFFFFF, 0, 1, 0, "R3");
      drive(0, 2, 24'hA5A5A5, 1, 1, 24'h812345, 0, -9, 24'h812345, 1, 1, 1, "R3");
      drive(0, -20, 24'h9ABCDE, 0, -20, 24'hF00001, 1, 70, 24'h800000, 0, 0, 0, "R4");
      drive(0, 0, 24'h800000, 0, 0, 24'h800000, 1, 63, 24'h800000, 0, 0, 0, "R4");
      drive(0, 0, 24'h800000, 0, 0, 24'h800000, 1, 64, 24'h800000, 0, 0, 0, "R4");
      drive(0, 0, 24'h800001, 0, 0, 24'h800001, 1, 40, 24'h800000, 0, 0, 0, "R4");
      drive(0, 30, 24'h800001, 0, 30, 24'h800001, 1, -60, 24'hFFFFFF, 0, 0, 0, "R4");

      for (int v = 0; v < 400; v++) begin
         logic [23:0] a, b, c;
         int ea, eb, ec;
         a  = {1'b1, 23'($urandom)};
         b  = {1'b1, 23'($urandom)};
         c  = {1'b1, 23'($urandom)};
         ea = int'($urandom_range(60)) - 30;
         eb = int'($urandom_range(60)) - 30;
         ec = (v % 3 == 0) ? ea + eb + int'($urandom_range(4)) - 2 : int'($urandom_range(140)) - 70;
         drive(1'($urandom), ea, a, 1'($urandom), eb, b, 1'($urandom), ec, c,
               1'($urandom), ($urandom_range(7) == 0), 1'($urandom), "R9");
         if ($urandom_range(3) == 0) @(negedge clk);
      end

      repeat (3) @(negedge clk);
      // R10: outputs hold while idle even with busy operand pins
      x_sig = 24'h123456; y_sig = 24'hFEDCBA; z_sig = 24'h999999;
      x_exp = 10'sd7; z_is_zero = 1'b1; rm_down = ~rm_down; neg_prod = ~neg_prod;
      repeat (4) @(negedge clk);
      n_checks++;
      if (out_valid !== 1'b0 || res_sign !== last_e.sign || int'(res_exp) != last_e.ex ||
          res_sig !== last_e.sig || res_zero !== last_e.zero) begin
         n_fails++;
         $display("FAIL R10: got sig=%h exp=%0d valid=%0d expected held sig=%h exp=%0d valid=0",
                  res_sig, int'(res_exp), out_valid, last_e.sig, last_e.ex);
      end
      n_checks++;
      if (sb_q.size() != 0) begin
         n_fails++;
         $display("FAIL R10: got %0d results missing expected 0", sb_q.size());
      end

      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end
endmodule